// File: doc/BRIEF.md
# Burst SRAM Address and Control Front End

This block is the synchronous front end of a burst cache SRAM, with a small word array behind it. On each rising clock edge it registers an address, three chip enables and the write controls. A two-bit beat counter then produces the low address bits for the following beats of a four-beat burst. Either a processor strobe or a controller strobe can open a burst. An advance input steps through the beats. A mode input picks interleaved (XOR) or linear (add, modulo 4) beat order. In both orders the beat bits wrap, so the upper address bits stay fixed for the whole burst.

Each data word has two 9-bit lanes, and each lane can be written on its own. Read data comes out registered, one clock after the access. A sleep input freezes the block, and no access is performed while it is high. The data output is split into a value (`dout`) and a drive-enable (`dout_en`). `dout_en` is the tri-state control, and it follows the output-enable pin asynchronously.

Top module: `bsram_front`

## Requirements
- R1: While reset is asserted, and after reset with no burst opened, `dout_en` is 0.
- R2: With `ce1_n`=0, `ce2`=1, `ce3_n`=0 and `adsp_n`=0, the address is loaded and read. After the next rising edge, `dout` holds the stored word and `dout_en` is 1, provided `oe_n`=0.
- R3: `adsp_n`=0 has no effect while `ce1_n`=1. A burst already open keeps its address and beat position.
- R4: A cycle opened by `adsp_n` is always a read, whatever the write inputs are. This holds even when `adsc_n` is also 0, because the processor strobe wins.
- R5: With `mode`=0, the beats read from low address bits start, start+1, start+2 and start+3, each taken modulo 4.
- R6: With `mode`=1, the beats read from low address bits start XOR 0, 1, 2 and 3.
- R7: With no strobe active and `adv_n`=1, the burst address is held, and the same word is read again.
- R8: After the fourth beat, one more advance returns the low bits to the start value. The upper address bits never change inside a burst.
- R9: `gw_n`=0 writes both lanes of the addressed word from `din`.
- R10: With `gw_n`=1 and `bwe_n`=0, a lane i is written only where `bw_n[i]`=0. Lane i is bits [9i+8:9i]. With no lane selected, the cycle is a read.
- R11: `dout_en` is 0 whenever `oe_n`=1, and it follows `oe_n` without a clock. It is also 0 after a write cycle.
- R12: While `zz`=1, no read or write takes place and the burst state does not change. `dout_en` is 0 after such a cycle.
- R13: If a strobe opens a cycle with `ce2`=0 or `ce3_n`=1, the block is deselected. That cycle and the advance cycles after it perform no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 18 | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Write of all lanes, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bw_n | input | 2 | Per-lane write selects, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Output drive enable (tri-state control) |

## Verification
The assertions assume that every control input is steady and known around each rising edge. They also assume that `mode` changes only between bursts, so that the beat order they check stays the same for a whole burst. The bench drives every input just after the falling edge and samples `dout` and `dout_en` just before the next change. It changes `mode` only in the cycle that opens a new burst. Memory words are always written before they are read, so no check ever compares against an undefined word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  // Low address bits for a beat, given the starting bits and the beat count.
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       ilv);
    logic [1:0] r;
    if (ilv) r = start ^ beat;
    else     r = start + beat;
    return r;
  endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl #(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              zz,
  input  logic              mode,
  output logic              acc,
  output logic              wr_ok,
  output logic [MEM_AW-1:0] acc_idx
);
  import bsram_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      lo0_q, lo0_d;
  logic [1:0]      cnt_q, cnt_d;
  logic            act_q, act_d;
  logic            p_start, c_start, strobe, sel_in, step, en;
  logic [1:0]      cur_lo;

  // Strobe decode: the processor strobe needs the primary enable and wins ties.
  always_comb begin
    p_start = !adsp_n && !ce1_n && !zz;
    c_start = !adsc_n && !p_start && !zz;
    strobe  = p_start || c_start;
    sel_in  = !ce1_n && ce2 && !ce3_n;
    step    = !strobe && !adv_n && !zz;
    en      = strobe || step;
  end

  // Next-state logic.
  always_comb begin
    hi_d  = hi_q;
    lo0_d = lo0_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (strobe) begin
      hi_d  = addr[ADDR_W-1:2];
      lo0_d = addr[1:0];
      cnt_d = 2'd0;
      act_d = sel_in;
    end else if (step) begin
      cnt_d = cnt_q + 2'd1;
    end
  end

  // Registers with explicit clock enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo0_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (en) begin
      hi_q  <= hi_d;
      lo0_q <= lo0_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // Address of the access in this cycle.
  always_comb begin
    cur_lo  = beat_lo(lo0_q, cnt_d, mode);
    acc     = !zz && (strobe ? sel_in : act_q);
    wr_ok   = acc && !p_start;
    acc_idx = strobe ? addr[MEM_AW-1:0] : {hi_q[MEM_AW-3:0], cur_lo};
  end

  // R2 / R8: a strobe loads the upper bits and restarts the beat count
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (hi_q == $past(addr[ADDR_W-1:2])) && (lo0_q == $past(addr[1:0]))
               && (cnt_q == 2'd0));

  // R8: an advance steps the counter by one beat and wraps
  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(hi_q));

  // R7 / R12: without strobe or advance the burst is frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !step) |=> $stable(cnt_q) && $stable(hi_q) && $stable(act_q));

  // R3: the processor strobe is ignored with the primary enable high
  a_r3_adsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n) |=> $stable(lo0_q) && $stable(act_q));

endmodule

// File: rtl/bsram_wr_dec.sv
module bsram_wr_dec #(
  parameter int NUM_LANES = 2
) (
  input  logic                 acc,
  input  logic                 wr_ok,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [NUM_LANES-1:0] bw_n,
  output logic [NUM_LANES-1:0] lane_we,
  output logic                 rd_en
);
  logic [NUM_LANES-1:0] lane_req;
  logic                 wr_req;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_req
    assign lane_req[i] = !gw_n || (!bwe_n && !bw_n[i]);
  end

  always_comb begin
    wr_req  = |lane_req;
    lane_we = wr_ok ? lane_req : '0;
    rd_en   = acc && !(wr_ok && wr_req);
  end

endmodule

// File: rtl/bsram_lane.sv
module bsram_lane #(
  parameter int LANE_W = 9,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] idx,
  input  logic              we,
  input  logic              re,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rdata_d;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb rdata_d = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rdata_d;
  end

endmodule

// File: rtl/bsram_front.sv
module bsram_front #(
  parameter int ADDR_W    = 18,
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 9,
  parameter int MEM_AW    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          adsp_n,
  input  logic                          adsc_n,
  input  logic                          adv_n,
  input  logic                          ce1_n,
  input  logic                          ce2,
  input  logic                          ce3_n,
  input  logic                          gw_n,
  input  logic                          bwe_n,
  input  logic [NUM_LANES-1:0]          bw_n,
  input  logic                          mode,
  input  logic                          oe_n,
  input  logic                          zz,
  input  logic [NUM_LANES*LANE_W-1:0]   din,
  output logic [NUM_LANES*LANE_W-1:0]   dout,
  output logic                          dout_en
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic [1:0]           rst_pipe;
  logic                 rst_ni;
  logic                 acc, wr_ok, rd_en;
  logic [MEM_AW-1:0]    acc_idx;
  logic [NUM_LANES-1:0] lane_we;
  logic [DATA_W-1:0]    rdata;
  logic                 rd_vld_q;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  bsram_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .addr(addr),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .zz(zz), .mode(mode),
    .acc(acc), .wr_ok(wr_ok), .acc_idx(acc_idx)
  );

  bsram_wr_dec #(.NUM_LANES(NUM_LANES)) u_wr (
    .acc(acc), .wr_ok(wr_ok), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .rd_en(rd_en)
  );

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    bsram_lane #(.LANE_W(LANE_W), .MEM_AW(MEM_AW)) u_lane (
      .clk(clk), .rst_n(rst_ni), .idx(acc_idx),
      .we(lane_we[i]), .re(rd_en),
      .wdata(din[i*LANE_W +: LANE_W]),
      .rdata(rdata[i*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_vld_q <= 1'b0;
    else         rd_vld_q <= rd_en;
  end

  assign dout    = rdata;
  assign dout_en = rd_vld_q && !oe_n;

  // R4: a processor-strobe cycle never writes
  a_r4_adsp_read: assert property (@(posedge clk) disable iff (!rst_ni)
    (!adsp_n && !ce1_n && !zz) |-> (lane_we == '0));

  // R12: nothing is read during sleep
  a_r12_sleep: assert property (@(posedge clk) disable iff (!rst_ni)
    zz |=> !rd_vld_q);

  // R11: a write cycle leaves the output undriven
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (|lane_we) |=> !rd_vld_q);

  // R13: a deselecting strobe cycle performs no access
  a_r13_deselect: assert property (@(posedge clk) disable iff (!rst_ni)
    ((!adsc_n || (!adsp_n && !ce1_n)) && !zz && (!ce2 || ce3_n)) |=> !rd_vld_q);

endmodule

// File: tb/sim_bsram_front.sv
module sim_bsram_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] BASE = 18'h2A4C0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] addr;
  logic        adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n;
  logic        gw_n, bwe_n, mode, oe_n, zz;
  logic [1:0]  bw_n;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dout_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [17:0] ref_mem [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bsram_front u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .mode(mode), .oe_n(oe_n), .zz(zz),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input int i);
    return 18'h0B3C5 ^ (18'(i) * 18'h02493);
  endfunction

  task automatic idle();
    addr = BASE; adsp_n = 1; adsc_n = 1; adv_n = 1;
    ce1_n = 0; ce2 = 1; ce3_n = 0; gw_n = 1; bwe_n = 1; bw_n = 2'b11;
    oe_n = 0; zz = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rd(input string tag, input logic [17:0] exp);
    n_chk++;
    if (dout_en !== 1'b1 || dout !== exp) begin
      n_fail++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=1 dout=%h", tag, dout_en, dout, exp);
    end
  endtask

  task automatic chk_off(input string tag);
    n_chk++;
    if (dout_en !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: dout_en=%b expected 0", tag, dout_en);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Open a burst with the controller strobe (read unless write inputs set).
  task automatic open_c(input int i, input logic m);
    idle(); adsc_n = 0; addr = BASE + 18'(i); mode = m;
    tick();
    idle();
  endtask

  task automatic advance();
    idle(); adv_n = 0;
    tick();
    idle();
  endtask

  task automatic t_reset();
    idle(); mode = 0; rst_n = 0;
    repeat (3) tick();
    chk_off("R1 during reset");
    rst_n = 1;
    repeat (3) tick();
    chk_off("R1 after reset, no burst");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) begin
      idle(); adsc_n = 0; gw_n = 0; addr = BASE + 18'(i); din = pat(i);
      tick();
      ref_mem[i] = pat(i);
      if (i == 0) chk_off("R11 no drive after write");
    end
    idle();
    open_c(7, 0);
    chk_rd("R9 global write both lanes", ref_mem[7]);
  endtask

  task automatic t_linear();
    idle(); adsp_n = 0; addr = BASE + 18'd1; mode = 0;
    tick();
    chk_rd("R2 processor strobe read", ref_mem[1]);
    advance(); chk_rd("R5 linear beat 2", ref_mem[2]);
    advance(); chk_rd("R5 linear beat 3", ref_mem[3]);
    advance(); chk_rd("R5 linear beat 4 wraps", ref_mem[0]);
    advance(); chk_rd("R8 fifth beat back to start", ref_mem[1]);
  endtask

  task automatic t_interleave();
    mode = 1;
    open_c(1, 1); chk_rd("R6 ilv start 1", ref_mem[1]);
    mode = 1; advance(); chk_rd("R6 ilv beat 2 from 1", ref_mem[0]);
    mode = 1; advance(); chk_rd("R6 ilv beat 3 from 1", ref_mem[3]);
    mode = 1; advance(); chk_rd("R6 ilv beat 4 from 1", ref_mem[2]);
    open_c(2, 1); chk_rd("R6 ilv start 2", ref_mem[2]);
    mode = 1; advance(); chk_rd("R6 ilv beat 2 from 2", ref_mem[3]);
    mode = 1; advance(); chk_rd("R6 ilv beat 3 from 2", ref_mem[0]);
    mode = 1; advance(); chk_rd("R6 ilv beat 4 from 2", ref_mem[1]);
    mode = 0;
  endtask

  task automatic t_hold_and_ignore();
    open_c(2, 0);
    mode = 0; idle(); tick();
    chk_rd("R7 held address re-read", ref_mem[2]);
    idle(); ce1_n = 1; adsp_n = 0; addr = BASE + 18'd5;
    tick();
    chk_rd("R3 ignored strobe keeps burst", ref_mem[2]);
    advance();
    chk_rd("R3 burst continues from old address", ref_mem[3]);
  endtask

  task automatic t_priority();
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; din = 18'h00000; addr = BASE + 18'd4;
    tick();
    chk_rd("R4 both strobes give read", ref_mem[4]);
    idle(); tick();
    chk_rd("R4 word not written", ref_mem[4]);
  endtask

  task automatic t_bytes();
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b10; din = 18'h3FFFF; addr = BASE + 18'd6;
    tick();
    ref_mem[6] = {ref_mem[6][17:9], 9'h1FF};
    chk_off("R11 lane write not driven");
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b11; din = 18'h00000; addr = BASE + 18'd6;
    tick();
    chk_rd("R10 lane 0 only written, none-selected reads", ref_mem[6]);
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 2'b01; din = 18'h00000; addr = BASE + 18'd5;
    tick();
    ref_mem[5] = {9'h000, ref_mem[5][8:0]};
    open_c(5, 0);
    chk_rd("R10 lane 1 only written", ref_mem[5]);
  endtask

  task automatic t_oe();
    open_c(3, 0);
    oe_n = 1; #1;
    chk_off("R11 oe high disables");
    oe_n = 0; #1;
    chk_rd("R11 oe low re-enables without clock", ref_mem[3]);
  endtask

  task automatic t_sleep();
    open_c(0, 0);
    idle(); zz = 1; adsc_n = 0; gw_n = 0; din = 18'h00000; addr = BASE + 18'd3;
    tick();
    chk_off("R12 no output in sleep");
    idle(); tick();
    chk_rd("R12 burst unchanged by sleep", ref_mem[0]);
    open_c(3, 0);
    chk_rd("R12 sleep write not performed", ref_mem[3]);
  endtask

  task automatic t_deselect();
    idle(); adsc_n = 0; ce2 = 0; addr = BASE + 18'd1;
    tick();
    chk_off("R13 ce2 low deselects");
    advance();
    chk_off("R13 advance while deselected");
    idle(); adsc_n = 0; ce3_n = 1; gw_n = 0; din = 18'h00000; addr = BASE + 18'd5;
    tick();
    chk_off("R13 ce3 high deselects");
    open_c(5, 0);
    chk_rd("R13 deselected write not performed", ref_mem[5]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_linear();
    t_interleave();
    t_hold_and_ignore();
    t_priority();
    t_bytes();
    t_oe();
    t_sleep();
    t_deselect();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

endmodule